// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic core of a small accumulator machine. It holds an accumulator register and a five-bit status register. Each cycle in which `op_valid` is high, it applies one operation to the accumulator and a second operand. The second operand is taken from the register input or from the immediate input, chosen by `use_imm`. The new accumulator value and the new flags are registered on the rising clock edge. Instruction decode and operand fetch happen upstream; the block sees only an operation code and the two candidate operands.

The operation set covers the following:
- add, subtract, and subtract with borrow;
- bitwise AND, OR, and XOR;
- a compare that changes only the flags;
- four rotates: two with a copy into carry, and two through carry;
- setting carry and inverting carry;
- a decimal correction after BCD addition.

The output `acc_wr` shows in the same cycle whether the current operation writes the accumulator. A compare leaves it low.

Top module: `acc_alu`

## Requirements
- R1: While `rst_n` is low and after it rises, `acc_q` is 00h and `flags_q` is 00000b until the first accepted operation. The flag bit positions are: bit 4 sign, bit 3 zero, bit 2 auxiliary carry, bit 1 parity, bit 0 carry.
- R2: The `op_sel` codes are:
  - 0 add, 1 subtract, 2 subtract with borrow;
  - 3 AND, 4 OR, 5 XOR, 6 compare;
  - 7 rotate left with copy, 8 rotate right with copy, 9 rotate left through carry, 10 rotate right through carry;
  - 11 set carry, 12 invert carry, 13 decimal adjust.

  For add, the accumulator becomes A plus the operand, modulo 256. Carry is the carry out of bit 7, and auxiliary carry is the carry out of bit 3. The operand is `imm_opnd` when `use_imm` is 1 and `reg_opnd` otherwise.
- R3: Subtract computes A minus the operand. Subtract with borrow also takes away the current carry flag. In both cases carry is set exactly when a borrow occurs. Auxiliary carry is the carry out of bit 3 of the sum A + ~operand + (1 − borrow-in).
- R4: Compare sets all five flags exactly as subtract would. It leaves `acc_q` unchanged and holds `acc_wr` low.
- R5: AND writes A & operand, sets auxiliary carry, and clears carry.
- R6: OR and XOR write their results and clear both carry and auxiliary carry. XOR of a value with itself gives 00h, with zero and parity set.
- R7: After every add, subtract, subtract-with-borrow, compare, logic, or decimal-adjust operation, the flags are set as follows:
  - sign is bit 7 of the result;
  - zero is set when the result is 00h;
  - parity is set when the result has an even number of 1 bits.
- R8: Rotate left with copy moves bit 7 into both bit 0 and carry. Rotate right with copy moves bit 0 into both bit 7 and carry.
- R9: Rotate right through carry moves bit 0 into carry and the old carry into bit 7. Rotate left through carry moves bit 7 into carry and the old carry into bit 0. None of the four rotates changes sign, zero, auxiliary carry, or parity.
- R10: Set-carry forces carry to 1. Invert-carry flips carry. Neither one changes the accumulator or any other flag.
- R11: Decimal adjust works in two steps:
  1. It adds 06h when the low nibble is above 9 or auxiliary carry is set. Auxiliary carry then becomes the carry out of bit 3 of that addition, or 0 if the addition was skipped.
  2. It then adds 60h when the high nibble of the intermediate value is above 9, when carry is set, or when step 1 carried out of bit 7. Carry becomes 1 exactly when this second correction is applied.
- R12: `acc_wr` is high exactly when `op_valid` is high and the code writes the accumulator (codes 0–5 and 7–10, and 13). Codes 14 and 15, and any cycle with `op_valid` low, leave `acc_q` and `flags_q` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Apply `op_sel` this cycle |
| op_sel | input | 4 | Operation code |
| use_imm | input | 1 | 1: operand from `imm_opnd`, 0: from `reg_opnd` |
| reg_opnd | input | DATA_W | Register operand |
| imm_opnd | input | DATA_W | Immediate operand |
| acc_wr | output | 1 | Current operation writes the accumulator |
| acc_q | output | DATA_W | Accumulator |
| flags_q | output | 5 | Sign, zero, aux carry, parity, carry (bit 4 to bit 0) |

## Verification
The bench builds the block with its default `DATA_W` of 8, which gives exactly two nibbles. With that width both stages of the decimal correction are visible at the ports. The cases include:
- a correction that only touches the low digit;
- a high-digit correction forced by an earlier carry;
- a first-stage overflow from FFh that must still trigger the second stage.

At 8 bits a sweep of BCD sums can also be checked against plain decimal arithmetic. In the same setting, carry and auxiliary carry sit at bits 7 and 3, so borrow and half-borrow can be driven directly with small operand pairs.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int NIB_W = 4;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_SBB  = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_XOR  = 4'd5,
    OP_CMP  = 4'd6,
    OP_RLC  = 4'd7,
    OP_RRC  = 4'd8,
    OP_RAL  = 4'd9,
    OP_RAR  = 4'd10,
    OP_STC  = 4'd11,
    OP_CMC  = 4'd12,
    OP_DAA  = 4'd13,
    OP_RSV0 = 4'd14,
    OP_RSV1 = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    ROT_LCOPY = 2'd0,
    ROT_RCOPY = 2'd1,
    ROT_LTHRU = 2'd2,
    ROT_RTHRU = 2'd3
  } rot_kind_e;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } flags_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              is_sub,
  input  logic              use_borrow,
  input  logic              cy_in,
  output logic [DATA_W-1:0] res,
  output logic              cy_out,
  output logic              ac_out
);
  import alu_pkg::*;

  localparam int SUM_W = DATA_W + 1;
  localparam int LO_W  = NIB_W + 1;

  logic [DATA_W-1:0] b_eff;
  logic              c_in;
  logic [SUM_W-1:0]  full_sum;
  logic [LO_W-1:0]   lo_sum;

  // Sum of width w from two operands and a carry-in.
  function automatic logic [SUM_W-1:0] wide_add(input logic [DATA_W-1:0] x,
                                               input logic [DATA_W-1:0] y,
                                               input logic ci);
    return {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, ci};
  endfunction

  function automatic logic [LO_W-1:0] nib_add(input logic [NIB_W-1:0] x,
                                              input logic [NIB_W-1:0] y,
                                              input logic ci);
    return {1'b0, x} + {1'b0, y} + {{NIB_W{1'b0}}, ci};
  endfunction

  always_comb begin
    b_eff    = is_sub ? ~b : b;
    c_in     = is_sub ? ~(use_borrow & cy_in) : 1'b0;
    full_sum = wide_add(a, b_eff, c_in);
    lo_sum   = nib_add(a[NIB_W-1:0], b_eff[NIB_W-1:0], c_in);
    res      = full_sum[DATA_W-1:0];
    cy_out   = is_sub ? ~full_sum[DATA_W] : full_sum[DATA_W];
    ac_out   = lo_sum[NIB_W];
  end

endmodule

// File: rtl/alu_rotate.sv
module alu_rotate #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0]   a,
  input  alu_pkg::rot_kind_e  kind,
  input  logic                cy_in,
  output logic [DATA_W-1:0]   res,
  output logic                cy_out
);
  import alu_pkg::*;

  always_comb begin
    unique case (kind)
      ROT_LCOPY: begin
        res    = {a[DATA_W-2:0], a[DATA_W-1]};
        cy_out = a[DATA_W-1];
      end
      ROT_RCOPY: begin
        res    = {a[0], a[DATA_W-1:1]};
        cy_out = a[0];
      end
      ROT_LTHRU: begin
        res    = {a[DATA_W-2:0], cy_in};
        cy_out = a[DATA_W-1];
      end
      default: begin
        res    = {cy_in, a[DATA_W-1:1]};
        cy_out = a[0];
      end
    endcase
  end

endmodule

// File: rtl/alu_bcd.sv
module alu_bcd #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic              ac_in,
  input  logic              cy_in,
  output logic [DATA_W-1:0] res,
  output logic              cy_out,
  output logic              ac_out
);
  import alu_pkg::*;

  localparam int RUN_W = DATA_W + 1;
  localparam int NIBS  = DATA_W / NIB_W;
  localparam logic [RUN_W-1:0] SIX = RUN_W'(6);

  logic [RUN_W-1:0] run [0:NIBS];
  logic [NIBS-1:0]  fix;
  logic [NIB_W:0]   lo_fix;

  function automatic logic over_nine(input logic [NIB_W-1:0] n);
    return n > NIB_W'(9);
  endfunction

  assign run[0] = {1'b0, a};

  // One correction stage per digit, each looking at the value left by the one below.
  for (genvar i = 0; i < NIBS; i++) begin : g_digit
    if (i == 0) begin : g_low
      assign fix[i] = over_nine(run[i][NIB_W*i +: NIB_W]) | ac_in;
    end else if (i == NIBS - 1) begin : g_top
      assign fix[i] = over_nine(run[i][NIB_W*i +: NIB_W]) | cy_in | run[i][DATA_W];
    end else begin : g_mid
      assign fix[i] = over_nine(run[i][NIB_W*i +: NIB_W]);
    end
    assign run[i+1] = fix[i] ? run[i] + (SIX << (NIB_W*i)) : run[i];
  end

  assign lo_fix = {1'b0, a[NIB_W-1:0]} + (NIB_W+1)'(6);
  assign res    = run[NIBS][DATA_W-1:0];
  assign cy_out = fix[NIBS-1];
  assign ac_out = fix[0] & lo_fix[NIB_W];

endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [3:0]        op_sel,
  input  logic              use_imm,
  input  logic [DATA_W-1:0] reg_opnd,
  input  logic [DATA_W-1:0] imm_opnd,
  output logic              acc_wr,
  output logic [DATA_W-1:0] acc_q,
  output logic [4:0]        flags_q
);
  import alu_pkg::*;

  alu_op_e           op_e;
  flags_t            flg_r, flg_nxt;
  logic [DATA_W-1:0] acc_r, opnd, result;
  logic              writes_acc, known_op, szp_upd;

  logic [DATA_W-1:0] as_res, rot_res, bcd_res;
  logic              as_cy, as_ac, rot_cy, bcd_cy, bcd_ac;
  logic              as_sub, as_brw;
  rot_kind_e         rot_kind;

  function automatic logic even_ones(input logic [DATA_W-1:0] v);
    return ~^v;
  endfunction

  assign op_e = alu_op_e'(op_sel);
  assign opnd = use_imm ? imm_opnd : reg_opnd;

  assign as_sub = (op_e == OP_SUB) || (op_e == OP_SBB) || (op_e == OP_CMP);
  assign as_brw = (op_e == OP_SBB);

  always_comb begin
    unique case (op_e)
      OP_RLC:  rot_kind = ROT_LCOPY;
      OP_RRC:  rot_kind = ROT_RCOPY;
      OP_RAL:  rot_kind = ROT_LTHRU;
      default: rot_kind = ROT_RTHRU;
    endcase
  end

  alu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a(acc_r), .b(opnd), .is_sub(as_sub), .use_borrow(as_brw), .cy_in(flg_r.cy),
    .res(as_res), .cy_out(as_cy), .ac_out(as_ac)
  );

  alu_rotate #(.DATA_W(DATA_W)) u_rotate (
    .a(acc_r), .kind(rot_kind), .cy_in(flg_r.cy), .res(rot_res), .cy_out(rot_cy)
  );

  alu_bcd #(.DATA_W(DATA_W)) u_bcd (
    .a(acc_r), .ac_in(flg_r.ac), .cy_in(flg_r.cy),
    .res(bcd_res), .cy_out(bcd_cy), .ac_out(bcd_ac)
  );

  always_comb begin
    result     = acc_r;
    flg_nxt    = flg_r;
    writes_acc = 1'b0;
    known_op   = 1'b1;
    szp_upd    = 1'b0;
    case (op_e)
      OP_ADD, OP_SUB, OP_SBB: begin
        result = as_res; flg_nxt.cy = as_cy; flg_nxt.ac = as_ac;
        writes_acc = 1'b1; szp_upd = 1'b1;
      end
      OP_CMP: begin
        result = as_res; flg_nxt.cy = as_cy; flg_nxt.ac = as_ac;
        szp_upd = 1'b1;
      end
      OP_AND: begin
        result = acc_r & opnd; flg_nxt.cy = 1'b0; flg_nxt.ac = 1'b1;
        writes_acc = 1'b1; szp_upd = 1'b1;
      end
      OP_OR: begin
        result = acc_r | opnd; flg_nxt.cy = 1'b0; flg_nxt.ac = 1'b0;
        writes_acc = 1'b1; szp_upd = 1'b1;
      end
      OP_XOR: begin
        result = acc_r ^ opnd; flg_nxt.cy = 1'b0; flg_nxt.ac = 1'b0;
        writes_acc = 1'b1; szp_upd = 1'b1;
      end
      OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
        result = rot_res; flg_nxt.cy = rot_cy; writes_acc = 1'b1;
      end
      OP_STC: flg_nxt.cy = 1'b1;
      OP_CMC: flg_nxt.cy = ~flg_r.cy;
      OP_DAA: begin
        result = bcd_res; flg_nxt.cy = bcd_cy; flg_nxt.ac = bcd_ac;
        writes_acc = 1'b1; szp_upd = 1'b1;
      end
      default: known_op = 1'b0;
    endcase
    if (szp_upd) begin
      flg_nxt.s = result[DATA_W-1];
      flg_nxt.z = (result == '0);
      flg_nxt.p = even_ones(result);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_r <= '0;
      flg_r <= '0;
    end else if (op_valid && known_op) begin
      if (writes_acc) acc_r <= result;
      flg_r <= flg_nxt;
    end
  end

  assign acc_wr  = op_valid & writes_acc;
  assign acc_q   = acc_r;
  assign flags_q = flg_r;

  // Named events for the checks below.
  logic ev_cmp, ev_rot, ev_logic, ev_stc, ev_cmc, ev_hold, ev_szp;
  assign ev_cmp   = rst_n && op_valid && (op_sel == 4'd6);
  assign ev_rot   = rst_n && op_valid && (op_sel >= 4'd7) && (op_sel <= 4'd10);
  assign ev_logic = rst_n && op_valid && (op_sel >= 4'd3) && (op_sel <= 4'd5);
  assign ev_stc   = rst_n && op_valid && (op_sel == 4'd11);
  assign ev_cmc   = rst_n && op_valid && (op_sel == 4'd12);
  assign ev_hold  = rst_n && (!op_valid || (op_sel >= 4'd14));
  assign ev_szp   = rst_n && op_valid && ((op_sel <= 4'd5) || (op_sel == 4'd13));

  a_r4_cmp_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cmp |=> $stable(acc_q));
  a_r4_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cmp |-> !acc_wr);
  a_r9_rot_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rot |=> (flags_q[4:1] == $past(flags_q[4:1])));
  a_r5_logic_clears_cy: assert property (@(posedge clk) disable iff (!rst_n)
    ev_logic |=> !flags_q[0]);
  a_r10_stc_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stc |=> flags_q[0] && $stable(acc_q));
  a_r10_cmc_flips: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cmc |=> (flags_q[0] != $past(flags_q[0])) && $stable(acc_q));
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hold |=> $stable(acc_q) && $stable(flags_q));
  a_r7_zero_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    ev_szp |=> (flags_q[3] == (acc_q == '0)));
  a_r7_sign_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    ev_szp |=> (flags_q[4] == acc_q[DATA_W-1]));

endmodule

// File: tb/test_acc_alu.sv
module test_acc_alu;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         op_valid = 1'b0;
  logic [3:0]   op_sel = 4'd0;
  logic         use_imm = 1'b0;
  logic [W-1:0] reg_opnd = '0;
  logic [W-1:0] imm_opnd = '0;
  logic         acc_wr;
  logic [W-1:0] acc_q;
  logic [4:0]   flags_q;

  int n_chk = 0;
  int n_fail = 0;
  int m_acc = 0;
  int m_fl = 0;   // bit4 s, bit3 z, bit2 ac, bit1 p, bit0 cy

  always #2.5 clk = ~clk;

  acc_alu #(.DATA_W(W)) i_acc_alu (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel), .use_imm(use_imm),
    .reg_opnd(reg_opnd), .imm_opnd(imm_opnd), .acc_wr(acc_wr), .acc_q(acc_q), .flags_q(flags_q)
  );

  function automatic int ones(input int v);
    int c = 0;
    for (int i = 0; i < 8; i++) c += (v >> i) & 1;
    return c;
  endfunction

  function automatic int szp(input int r, input int fl);
    int f = fl & 5'b00101;
    if (r >= 128) f |= 16;
    if (r == 0) f |= 8;
    if (ones(r) % 2 == 0) f |= 2;
    return f;
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // Apply one operation and compare acc, flags and acc_wr with the bench model.
  task automatic step(input int op, input bit imm, input int val, input string tag);
    int a = m_acc, cy = m_fl & 1, ac = (m_fl >> 2) & 1;
    int r = a, f = m_fl, wr = 1, t, ci, nb;
    case (op)
      0: begin t = a + val; r = t % 256; f = (t > 255 ? 1 : 0) | ((((a % 16) + (val % 16)) > 15) ? 4 : 0);
               f = szp(r, f); end
      1, 2, 6: begin
        ci = (op == 2) ? cy : 0; nb = 255 - val;
        t = a + nb + 1 - ci; r = t % 256;
        f = ((a < val + ci) ? 1 : 0) | ((((a % 16) + (nb % 16) + 1 - ci) > 15) ? 4 : 0);
        f = szp(r, f);
        if (op == 6) begin r = a; wr = 0; f = szp((a + nb + 1) % 256, f); end
      end
      3: begin r = a & val; f = szp(r, 4); end
      4: begin r = a | val; f = szp(r, 0); end
      5: begin r = a ^ val; f = szp(r, 0); end
      7: begin r = ((a * 2) % 256) | (a / 128); f = (m_fl & 30) | (a / 128); end
      8: begin r = (a / 2) | ((a % 2) * 128); f = (m_fl & 30) | (a % 2); end
      9: begin r = ((a * 2) % 256) | cy; f = (m_fl & 30) | (a / 128); end
      10: begin r = (a / 2) | (cy * 128); f = (m_fl & 30) | (a % 2); end
      11: begin wr = 0; f = m_fl | 1; end
      12: begin wr = 0; f = m_fl ^ 1; end
      13: begin
        int acn = 0, cyn = 0;
        t = a;
        if ((t % 16) > 9 || ac) begin acn = ((t % 16) + 6) > 15; t += 6; end
        if ((((t / 16) % 16) > 9) || cy || t > 255) begin t += 96; cyn = 1; end
        r = t % 256; f = szp(r, cyn | (acn * 4));
      end
      default: wr = 0;
    endcase
    op_valid = 1'b1; op_sel = op[3:0]; use_imm = imm;
    if (imm) begin imm_opnd = val[7:0]; reg_opnd = ~val[7:0]; end
    else begin reg_opnd = val[7:0]; imm_opnd = ~val[7:0]; end
    #1;
    check({tag, " acc_wr"}, int'(acc_wr), wr);
    @(negedge clk);
    op_valid = 1'b0;
    m_acc = r; m_fl = f;
    check({tag, " acc"}, int'(acc_q), r);
    check({tag, " flags"}, int'(flags_q), f);
  endtask

  task automatic load(input int v);
    step(3, 1, 0, "R5 clear");
    step(0, 1, v, "R2 R7 load");
  endtask

  task automatic t_reset;
    check("R1 acc", int'(acc_q), 0);
    check("R1 flags", int'(flags_q), 0);
  endtask

  task automatic t_add;
    load(8'h3A); step(0, 0, 8'hC6, "R2 R7 add wrap");
    check("R2 zero+carry", int'(flags_q), 5'b01111);
    load(8'h7F); step(0, 1, 8'h01, "R2 R7 add sign");
    check("R2 sign", int'(acc_q), 8'h80);
    load(8'h12); step(0, 0, 8'h21, "R2 R7 add reg");
  endtask

  task automatic t_sub;
    load(8'h05); step(1, 1, 8'h09, "R3 sub borrow");
    check("R3 borrow value", int'(acc_q), 8'hFC);
    load(8'h40); step(1, 0, 8'h01, "R3 sub half");
    load(8'h10); step(11, 0, 0, "R10 stc"); step(2, 1, 8'h0F, "R3 sbb with cy");
    check("R3 sbb value", int'(acc_q), 8'h00);
    load(8'h10); step(2, 1, 8'h0F, "R3 sbb no cy");
  endtask

  task automatic t_cmp;
    load(8'h05); step(6, 1, 8'h09, "R4 cmp less");
    check("R4 acc kept", int'(acc_q), 8'h05);
    step(6, 0, 8'h05, "R4 cmp equal");
    step(6, 1, 8'h01, "R4 cmp greater");
  endtask

  task automatic t_logic;
    load(8'hF3); step(11, 0, 0, "R10 stc"); step(3, 0, 8'h3C, "R5 and");
    step(4, 1, 8'h81, "R6 or");
    step(11, 0, 0, "R10 stc"); step(5, 1, 8'hFF, "R6 xor");
    step(5, 0, m_acc, "R6 xor self");
    check("R6 self zero", int'(flags_q), 5'b01010);
  endtask

  task automatic t_rot;
    load(8'h81); step(12, 0, 0, "R10 cmc");
    step(7, 0, 0, "R8 rlc");
    step(8, 0, 0, "R8 rrc");
    step(12, 0, 0, "R10 cmc");
    step(10, 0, 0, "R9 rar");
    step(10, 0, 0, "R9 rar again");
    step(9, 0, 0, "R9 ral");
    step(9, 0, 0, "R9 ral again");
  endtask

  task automatic t_carry;
    load(8'h55);
    step(11, 0, 0, "R10 stc"); step(11, 0, 0, "R10 stc twice");
    step(12, 0, 0, "R10 cmc"); step(12, 0, 0, "R10 cmc back");
  endtask

  task automatic t_daa;
    load(8'h15); step(0, 1, 8'h27, "R2 add"); step(13, 0, 0, "R11 daa low");
    check("R11 42", int'(acc_q), 8'h42);
    load(8'h99); step(0, 1, 8'h01, "R2 add"); step(13, 0, 0, "R11 daa both");
    check("R11 00 carry", int'(flags_q[0]), 1);
    load(8'h09); step(0, 1, 8'h09, "R2 add"); step(13, 0, 0, "R11 daa aux");
    check("R11 18", int'(acc_q), 8'h18);
    load(8'h90); step(0, 1, 8'h90, "R2 add"); step(13, 0, 0, "R11 daa by carry");
    check("R11 80", int'(acc_q), 8'h80);
    load(8'hFF); step(13, 0, 0, "R11 daa overflow");
    check("R11 65", int'(acc_q), 8'h65);
    for (int i = 0; i < 100; i += 7) begin
      int x = (i / 10) * 16 + (i % 10), y = ((99 - i) / 10 % 10) * 16 + ((99 - i + 3) % 10);
      int dec = i + (99 - i) / 10 % 10 * 10 + (99 - i + 3) % 10;
      load(x); step(0, 1, y, "R11 sweep add"); step(13, 0, 0, "R11 sweep daa");
      check("R11 decimal", int'(acc_q), ((dec % 100) / 10) * 16 + dec % 10);
      check("R11 decimal carry", int'(flags_q[0]), dec > 99 ? 1 : 0);
    end
  endtask

  task automatic t_idle;
    load(8'hA5); step(11, 0, 0, "R10 stc");
    step(14, 1, 8'h00, "R12 code 14");
    step(15, 0, 8'hFF, "R12 code 15");
    op_sel = 4'd0; use_imm = 1'b1; imm_opnd = 8'h33;
    @(negedge clk); @(negedge clk);
    check("R12 idle acc", int'(acc_q), 8'hA5);
    check("R12 idle flags", int'(flags_q), m_fl);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 acc in reset", int'(acc_q), 0);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_add();
    t_sub();
    t_cmp();
    t_logic();
    t_rot();
    t_carry();
    t_daa();
    t_idle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule